// File: doc/BRIEF.md
# Serial Volume Control Port

This block receives attenuation and mute settings for a stereo audio stream over a three-wire control link and applies them to the samples. The link has a bit clock, a data line and a latch strobe. The block samples all three with the system clock and detects their edges. Each rising edge of the control clock shifts one data bit into a 16-bit word. A rising edge of the latch commits that word to the left or the right channel register. The control clock may stop between words, and extra clock pulses before a word do no harm, because only the last sixteen bits count.

Each channel holds a 10-bit attenuation code and a soft-mute bit. The block multiplies every 24-bit sample by an effective gain. That gain moves toward its target by one step per sample, so a change of volume, a soft mute or a hardware mute produces a ramp and not a jump. The power-down input returns the block to its defaults and blocks all output samples while it is held low.

Top module: `svc_port`

## Requirements
- R1: While pd_ni is low and after rst_ni, both channels hold code 1023 with mute off, both effective gains return to 1023, and smp_valid_o stays low.
- R2: A data bit is taken on each rising edge of the control clock, MSB first. Only the last 16 bits shifted before the latch edge form the word, so extra or gated clock pulses before a word are harmless.
- R3: Registers change only on a rising edge of the latch. Words shifted in without a latch edge leave every output unchanged.
- R4: Word bit 15 picks the channel (0 = left, 1 = right). A commit leaves the other channel unchanged.
- R5: Word bit 14 is the soft-mute bit and bits 9:0 are the attenuation code, where 1023 means unity and 0 means off. Bits 13:10 are ignored.
- R6: An output sample equals floor(s*k/1024), with k = 1024 when the effective gain is 1023 and k = the gain otherwise. It appears, together with a one-cycle smp_valid_o pulse, on the clock after smp_valid_i.
- R7: At each accepted sample, the effective gain steps by one toward its target. The target is 0 when the channel is muted and the attenuation code otherwise. A sample uses the gain as it was before that step. Between samples the gain holds.
- R8: While hw_mute_i is high, the target of both channels is 0. When it goes low, the targets return to the attenuation codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Power-down, active low |
| ctl_clk_i | input | 1 | Control bit clock |
| ctl_dat_i | input | 1 | Control serial data |
| ctl_lat_i | input | 1 | Control latch strobe |
| hw_mute_i | input | 1 | Hardware mute for both channels |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_l_i | input | 24 | Left sample, two's complement |
| smp_r_i | input | 24 | Right sample, two's complement |
| smp_valid_o | output | 1 | Output sample strobe |
| smp_l_o | output | 24 | Attenuated left sample |
| smp_r_o | output | 24 | Attenuated right sample |
| atten_l_o | output | 10 | Left attenuation code |
| atten_r_o | output | 10 | Right attenuation code |
| mute_l_o | output | 1 | Left soft-mute bit |
| mute_r_o | output | 1 | Right soft-mute bit |

## Verification
The assertions rely on the control pins changing slowly compared with clk_i. Each level must last at least three system clocks, so the synchronizers see every edge. The data line must be settled before the control clock rises, and the latch must never rise in the same cycle as the control clock. The bench meets these conditions by holding each control level for four clocks. It drives data only while the control clock is low and raises the latch only after the clock has returned low. It presents random samples at most once every two cycles.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int WORD_W   = 16;
  localparam int ATT_W    = 10;
  localparam int NCH      = 2;
  localparam int SEL_BIT  = 15;
  localparam int MUTE_BIT = 14;

  typedef struct packed {
    logic             mute;
    logic [ATT_W-1:0] atten;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_DEF = '{mute: 1'b0, atten: {ATT_W{1'b1}}};
endpackage

// File: rtl/svc_ctl.sv
module svc_ctl
  import svc_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pd_ni,
  input  logic                  ctl_clk_i,
  input  logic                  ctl_dat_i,
  input  logic                  ctl_lat_i,
  output chan_cfg_t [NCH-1:0]   cfg_o
);
  logic [SYNC_N:0]     clk_s, dat_s, lat_s;
  logic [WORD_W-1:0]   word_q;
  chan_cfg_t [NCH-1:0] cfg_q;
  logic                clk_rise, lat_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_s <= '0;
      dat_s <= '0;
      lat_s <= '0;
    end else begin
      clk_s <= {clk_s[SYNC_N-1:0], ctl_clk_i};
      dat_s <= {dat_s[SYNC_N-1:0], ctl_dat_i};
      lat_s <= {lat_s[SYNC_N-1:0], ctl_lat_i};
    end
  end

  assign clk_rise = clk_s[SYNC_N-1] & ~clk_s[SYNC_N];
  assign lat_rise = lat_s[SYNC_N-1] & ~lat_s[SYNC_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cfg_q  <= {NCH{CFG_DEF}};
    end else if (!pd_ni) begin
      word_q <= '0;
      cfg_q  <= {NCH{CFG_DEF}};
    end else begin
      if (clk_rise) word_q <= {word_q[WORD_W-2:0], dat_s[SYNC_N-1]};
      if (lat_rise)
        cfg_q[word_q[SEL_BIT]] <= '{mute: word_q[MUTE_BIT], atten: word_q[ATT_W-1:0]};
    end
  end

  assign cfg_o = cfg_q;

  // settings move only after a latch edge
  assert_cfg_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pd_ni) && !$past(lat_rise)) |-> $stable(cfg_q));
endmodule

// File: rtl/svc_chan.sv
module svc_chan
  import svc_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  chan_cfg_t        cfg_i,
  input  logic             hw_mute_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [SMP_W-1:0] smp_o
);
  localparam int PROD_W = SMP_W + ATT_W + 2;

  logic [ATT_W-1:0]         gain_q, tgt;
  logic [ATT_W:0]           scale;
  logic signed [PROD_W-1:0] a_s, b_s, prod, shifted;
  logic [SMP_W-1:0]         smp_q;

  assign tgt   = (hw_mute_i || cfg_i.mute) ? '0 : cfg_i.atten;
  assign scale = (gain_q == {ATT_W{1'b1}}) ? (ATT_W+1)'(1 << ATT_W) : {1'b0, gain_q};
  assign a_s   = PROD_W'($signed(smp_i));
  assign b_s   = PROD_W'($signed({1'b0, scale}));
  assign prod  = a_s * b_s;
  assign shifted = prod >>> ATT_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '1;
      smp_q  <= '0;
    end else if (!pd_ni) begin
      gain_q <= '1;
      smp_q  <= '0;
    end else if (smp_valid_i) begin
      smp_q <= shifted[SMP_W-1:0];
      if (gain_q > tgt)      gain_q <= gain_q - 1'b1;
      else if (gain_q < tgt) gain_q <= gain_q + 1'b1;
    end
  end

  assign smp_o = smp_q;

  assert_gain_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pd_ni) |-> (gain_q == $past(gain_q) ||
                      gain_q == ATT_W'($past(gain_q) + 1'b1) ||
                      gain_q == ATT_W'($past(gain_q) - 1'b1)));
  assert_gain_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pd_ni) && !$past(smp_valid_i)) |-> $stable(gain_q));
  assert_hw_mute_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pd_ni) && $past(hw_mute_i)) |-> (gain_q <= $past(gain_q)));
endmodule

// File: rtl/svc_port.sv
module svc_port
  import svc_pkg::*;
#(
  parameter int SMP_W  = 24,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic             ctl_clk_i,
  input  logic             ctl_dat_i,
  input  logic             ctl_lat_i,
  input  logic             hw_mute_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic [SMP_W-1:0] smp_r_i,
  output logic             smp_valid_o,
  output logic [SMP_W-1:0] smp_l_o,
  output logic [SMP_W-1:0] smp_r_o,
  output logic [ATT_W-1:0] atten_l_o,
  output logic [ATT_W-1:0] atten_r_o,
  output logic             mute_l_o,
  output logic             mute_r_o
);
  chan_cfg_t [NCH-1:0] cfg;
  logic [NCH-1:0][SMP_W-1:0] smp_in, smp_out;
  logic valid_q;

  svc_ctl #(.SYNC_N(SYNC_N)) u_ctl (
    .clk_i, .rst_ni, .pd_ni,
    .ctl_clk_i, .ctl_dat_i, .ctl_lat_i,
    .cfg_o(cfg)
  );

  assign smp_in[0] = smp_l_i;
  assign smp_in[1] = smp_r_i;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    svc_chan #(.SMP_W(SMP_W)) u_chan (
      .clk_i, .rst_ni, .pd_ni,
      .cfg_i(cfg[c]),
      .hw_mute_i,
      .smp_valid_i,
      .smp_i(smp_in[c]),
      .smp_o(smp_out[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= pd_ni & smp_valid_i;
  end

  assign smp_valid_o = valid_q;
  assign smp_l_o     = smp_out[0];
  assign smp_r_o     = smp_out[1];
  assign atten_l_o   = cfg[0].atten;
  assign atten_r_o   = cfg[1].atten;
  assign mute_l_o    = cfg[0].mute;
  assign mute_r_o    = cfg[1].mute;

  assert_pd_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pd_ni) |-> !smp_valid_o);
  assert_pd_default_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pd_ni) |-> (atten_l_o == '1 && atten_r_o == '1 && !mute_l_o && !mute_r_o));
  assert_valid_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pd_ni) && $past(smp_valid_i)) |-> smp_valid_o);
endmodule

// File: tb/sim_svc_port.sv
module sim_svc_port;
  logic clk = 1'b0;
  logic rst_ni = 1'b0, pd_ni = 1'b1;
  logic ctl_clk = 1'b0, ctl_dat = 1'b0, ctl_lat = 1'b0, hw_mute = 1'b0;
  logic smp_valid_i = 1'b0;
  logic [23:0] smp_l_i = '0, smp_r_i = '0;
  logic smp_valid_o, mute_l_o, mute_r_o;
  logic [23:0] smp_l_o, smp_r_o;
  logic [9:0] atten_l_o, atten_r_o;

  int errs = 0, checks = 0;
  int m_att [2];
  bit m_mute [2];
  int m_gain [2];

  always #5 clk = ~clk;

  svc_port u0 (
    .clk_i(clk), .rst_ni, .pd_ni,
    .ctl_clk_i(ctl_clk), .ctl_dat_i(ctl_dat), .ctl_lat_i(ctl_lat),
    .hw_mute_i(hw_mute), .smp_valid_i, .smp_l_i, .smp_r_i,
    .smp_valid_o, .smp_l_o, .smp_r_o,
    .atten_l_o, .atten_r_o, .mute_l_o, .mute_r_o
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_out(input logic [23:0] s, input int g);
    longint k, p;
    k = (g == 1023) ? 1024 : g;
    p = longint'($signed(s)) * k;
    p = p >>> 10;
    return p[23:0];
  endfunction

  function automatic int tgt(input int c);
    return (hw_mute || m_mute[c]) ? 0 : m_att[c];
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ctl_dat = w[i]; ctl_clk = 1'b0; wait_n(4);
      ctl_clk = 1'b1; wait_n(4);
    end
    ctl_clk = 1'b0; wait_n(4);
  endtask

  task automatic latch_word(input logic [15:0] w);
    ctl_lat = 1'b1; wait_n(4);
    ctl_lat = 1'b0; wait_n(6);
    m_att[w[15]]  = int'(w[9:0]);
    m_mute[w[15]] = w[14];
  endtask

  task automatic check_cfg(input string tag);
    chk(atten_l_o == m_att[0][9:0], {tag, " atten_l"}, atten_l_o, m_att[0]);
    chk(atten_r_o == m_att[1][9:0], {tag, " atten_r"}, atten_r_o, m_att[1]);
    chk(mute_l_o == m_mute[0], {tag, " mute_l"}, mute_l_o, m_mute[0]);
    chk(mute_r_o == m_mute[1], {tag, " mute_r"}, mute_r_o, m_mute[1]);
  endtask

  task automatic do_sample(input logic [23:0] l, input logic [23:0] r, input string tag);
    logic [23:0] el, er;
    @(negedge clk);
    smp_valid_i = 1'b1; smp_l_i = l; smp_r_i = r;
    el = exp_out(l, m_gain[0]);
    er = exp_out(r, m_gain[1]);
    for (int c = 0; c < 2; c++) begin
      if (m_gain[c] > tgt(c)) m_gain[c]--;
      else if (m_gain[c] < tgt(c)) m_gain[c]++;
    end
    @(negedge clk);
    smp_valid_i = 1'b0;
    chk(smp_valid_o == 1'b1, {tag, " valid R6"}, smp_valid_o, 1);
    chk(smp_l_o == el, {tag, " left"}, $signed(smp_l_o), $signed(el));
    chk(smp_r_o == er, {tag, " right"}, $signed(smp_r_o), $signed(er));
  endtask

  task automatic rand_samples(input int n, input string tag);
    for (int i = 0; i < n; i++) do_sample(24'($urandom), 24'($urandom), tag);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    m_att = '{1023, 1023}; m_mute = '{0, 0}; m_gain = '{1023, 1023};
    wait_n(3);
    check_cfg("R1 reset");
    rst_ni = 1'b1;
    wait_n(2);
    check_cfg("R1 after reset");

    // R6 unity passes exactly, corner values
    do_sample(24'h7FFFFF, 24'h800000, "R6 unity extremes");
    chk(smp_l_o == 24'h7FFFFF, "R6 unity left", smp_l_o, 24'h7FFFFF);
    do_sample(24'hFFFFFF, 24'h000001, "R6 unity small");

    // R4 left write, right unchanged
    send_bits(32'(16'h0000 | 16'd500), 16);
    latch_word(16'h0000 | 16'd500);
    check_cfg("R4 left write");

    // R5 reserved bits ignored on right
    send_bits(32'(16'h8000 | 16'h3C00 | 16'd300), 16);
    latch_word(16'h8000 | 16'd300);
    check_cfg("R5 reserved ignored");

    // R3 shift without latch
    send_bits(32'(16'h8000 | 16'd5), 16);
    wait_n(6);
    check_cfg("R3 no latch");

    // R2 extra leading pulses, last 16 bits win
    send_bits({12'h0, 4'hB, 16'h8000 | 16'd700}, 20);
    latch_word(16'h8000 | 16'd700);
    check_cfg("R2 extra pulses");

    // R7 ramps toward new codes
    rand_samples(600, "R7 ramp");
    chk(m_gain[0] == 500, "R7 left settled", m_gain[0], 500);

    // R5 soft mute on left
    send_bits(32'(16'h4000 | 16'd500), 16);
    latch_word(16'h4000 | 16'd500);
    check_cfg("R5 soft mute");
    rand_samples(520, "R7 mute ramp");
    do_sample(24'h400000, 24'h400000, "R7 muted");
    chk(smp_l_o == 24'h0, "R7 left silent", smp_l_o, 0);

    // unmute left, then hardware mute
    send_bits(32'(16'd800), 16);
    latch_word(16'd800);
    rand_samples(100, "R7 unmute ramp");
    hw_mute = 1'b1;
    rand_samples(800, "R8 hw mute");
    do_sample(24'h7FFFFF, 24'h7FFFFF, "R8 silent");
    chk(smp_l_o == 24'h0 && smp_r_o == 24'h0, "R8 both silent", smp_l_o | smp_r_o, 0);
    hw_mute = 1'b0;
    rand_samples(50, "R8 release");
    chk(m_gain[1] == 50, "R8 right rising", m_gain[1], 50);

    // R1 power-down
    @(negedge clk); pd_ni = 1'b0;
    wait_n(2);
    m_att = '{1023, 1023}; m_mute = '{0, 0}; m_gain = '{1023, 1023};
    check_cfg("R1 power-down");
    @(negedge clk); smp_valid_i = 1'b1; smp_l_i = 24'h123456;
    @(negedge clk); smp_valid_i = 1'b0;
    chk(smp_valid_o == 1'b0, "R1 no valid in pd", smp_valid_o, 0);
    pd_ni = 1'b1;
    wait_n(2);
    check_cfg("R1 after pd");
    rand_samples(20, "R1 unity after pd");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule